// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Controller

This block controls the four gate enables of one H-bridge winding. It regulates current by peak detection. While a diagonal pair conducts, the block waits for a synchronized trip bit from an external current comparator. When the trip arrives, the bridge goes into a decay interval of fixed length. When that interval ends, the same diagonal pair is switched back on. The direction bit selects which diagonal pair drives.

During the off interval the block applies one of three decay policies:
- **Slow decay:** only the high side opens, so current recirculates through both low-side switches.
- **Fast decay:** the bridge swaps to the opposite diagonal pair.
- **Mixed decay:** a programmable fast portion runs first, then slow decay for the rest of the interval.

The comparator is blanked after three events: the start of a drive period after an off interval, a direction change, and re-enabling from the all-zero level code. A direction change also forces all switches off for a dead time before the new pair is driven.

A thermal fault input turns every switch off. The outputs come back only after the fault has stayed clear for a hold-off count.

The magnitude bits of the level code go to an external reference generator. Only their all-zero value matters here. Off time, blanking, dead time and fault hold-off are clock-cycle counts set by parameters. The fast portion is a port.

Top module: `pwm_offtime_ctrl`

## Requirements
- R1: After reset, and one cycle after the level code becomes 3'b000, all four gate enables are low.
- R2: In the drive phase with direction 1, the A high side and B low side are on (gates {ha,la,hb,lb} = 4'b1001). With direction 0, the B high side and A low side are on (4'b0110).
- R3: For BLANK_CYC cycles after each blanking trigger, the trip bit is ignored. With the trip held high, every drive period therefore lasts BLANK_CYC+1 cycles.
- R4: A trip during the drive phase starts an off interval of exactly OFF_CYC cycles. After it, the same diagonal pair drives again.
- R5: With decay select 2'b00 (slow), the off interval shows 4'b0101: both low sides on, both high sides off.
- R6: With decay select 2'b01 (fast), the off interval shows the opposite diagonal pair.
- R7: With decay select 2'b10 or 2'b11 (mixed), the first min(fast_len_i, OFF_CYC) off cycles are fast decay and the rest are slow decay.
- R8: A direction change while the block is enabled and not idle gives DEAD_CYC cycles of all gates off. Blanking then follows, using the new pair. A change while idle adds no dead time.
- R9: A high fault input turns all gates off from the next cycle on. Driving resumes only after the fault has been low for FLT_CYC consecutive cycles.
- R10: The high and low enables of the same terminal are never both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Synchronized current-trip comparator bit |
| dir_i | input | 1 | Current direction select |
| level_i | input | 3 | Current level code; 3'b000 disables the bridge |
| decay_sel_i | input | 2 | 00 slow, 01 fast, 1x mixed |
| fast_len_i | input | CW | Fast-decay portion of the off interval, in cycles |
| fault_i | input | 1 | Thermal fault, high while over temperature |
| ha_o | output | 1 | Terminal A high-side enable |
| la_o | output | 1 | Terminal A low-side enable |
| hb_o | output | 1 | Terminal B high-side enable |
| lb_o | output | 1 | Terminal B low-side enable |

## Verification
The sharpest overlap is between comparator blanking and trip detection. A trip bit held high from the first enabled cycle must still leave exactly BLANK_CYC+1 drive cycles before the decay pattern appears.

The same overlap is provoked when a direction change arrives together with a raised trip. The expected gate stream is then dead time, then blanking with the new pair, then one drive cycle, then decay.

A scoreboard queue holds the expected gate vector for every cycle, and each vector is judged against the outputs in the cycle it belongs to.

// File: rtl/pwm_offtime_ctrl.sv
module pwm_offtime_ctrl #(
  parameter int CW        = 8,
  parameter int OFF_CYC   = 10,
  parameter int BLANK_CYC = 3,
  parameter int DEAD_CYC  = 2,
  parameter int FLT_CYC   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_i,
  input  logic          dir_i,
  input  logic [2:0]    level_i,
  input  logic [1:0]    decay_sel_i,
  input  logic [CW-1:0] fast_len_i,
  input  logic          fault_i,
  output logic          ha_o,
  output logic          la_o,
  output logic          hb_o,
  output logic          lb_o
);

  localparam logic [CW-1:0] OFF_W    = CW'(OFF_CYC);
  localparam logic [CW-1:0] OFF_M1   = CW'(OFF_CYC - 1);
  localparam logic [CW-1:0] BLANK_M1 = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] DEAD_M1  = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] FLT_W    = CW'(FLT_CYC);

  typedef enum logic [2:0] {S_IDLE, S_DEAD, S_BLANK, S_DRIVE, S_OFF} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] fclr;
  logic          dir_q;
  logic [3:0]    g;

  wire           fault_act = fault_i | (fclr < FLT_W);
  wire           enable    = (|level_i) & ~fault_act;
  wire [CW-1:0]  fast_eff  = (fast_len_i > OFF_W) ? OFF_W : fast_len_i;
  wire [3:0]     drv_pat   = dir_q ? 4'b1001 : 4'b0110;
  wire [3:0]     rev_pat   = dir_q ? 4'b0110 : 4'b1001;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      dir_q <= 1'b0;
      fclr  <= FLT_W;
    end else begin
      if (fault_i)            fclr <= '0;
      else if (fclr < FLT_W)  fclr <= fclr + 1'b1;

      if (!enable) begin
        st    <= S_IDLE;
        cnt   <= '0;
        dir_q <= dir_i;
      end else if (st == S_IDLE) begin
        st    <= S_BLANK;
        cnt   <= '0;
        dir_q <= dir_i;
      end else if (dir_i != dir_q) begin
        st    <= S_DEAD;
        cnt   <= '0;
        dir_q <= dir_i;
      end else begin
        case (st)
          S_DEAD:
            if (cnt == DEAD_M1) begin st <= S_BLANK; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          S_BLANK:
            if (cnt == BLANK_M1) begin st <= S_DRIVE; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          S_DRIVE:
            if (trip_i) begin st <= S_OFF; cnt <= '0; end
          S_OFF:
            if (cnt == OFF_M1) begin st <= S_BLANK; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          default: begin st <= S_IDLE; cnt <= '0; end
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_BLANK, S_DRIVE: g = drv_pat;
      S_OFF:
        case (decay_sel_i)
          2'b00:   g = 4'b0101;
          2'b01:   g = rev_pat;
          default: g = (cnt < fast_eff) ? rev_pat : 4'b0101;
        endcase
      default: g = 4'b0000;
    endcase
  end

  assign {ha_o, la_o, hb_o, lb_o} = g;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !((ha_o && la_o) || (hb_o && lb_o))); // R10

  AST_ZERO_LEVEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == 3'b000) |=> !(ha_o || la_o || hb_o || lb_o)); // R1

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !(ha_o || la_o || hb_o || lb_o)); // R9

  AST_DIR_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && enable && dir_i != dir_q) |=> !(ha_o || la_o || hb_o || lb_o)); // R8

  AST_BLANK_IGNORES_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BLANK && enable && dir_i == dir_q) |=> (ha_o || hb_o)); // R3

endmodule

// File: tb/pwm_offtime_ctrl_tb.sv
module pwm_offtime_ctrl_tb;
  localparam int CW = 8;
  localparam int OFF_CYC = 10;
  localparam int BLANK_CYC = 3;
  localparam int DEAD_CYC = 2;
  localparam int FLT_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0, dir = 1'b0, fault = 1'b0;
  logic [2:0] level = 3'b000;
  logic [1:0] dsel = 2'b00;
  logic [CW-1:0] flen = '0;
  logic ha, la, hb, lb;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [3:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  pwm_offtime_ctrl #(.CW(CW), .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC),
                     .DEAD_CYC(DEAD_CYC), .FLT_CYC(FLT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .dir_i(dir), .level_i(level),
    .decay_sel_i(dsel), .fast_len_i(flen), .fault_i(fault),
    .ha_o(ha), .la_o(la), .hb_o(hb), .lb_o(lb));

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      checks++;
      if ((ha && la) || (hb && lb)) begin
        fails++;
        $display("FAIL R10: gates=%b expected no leg with both enables", {ha, la, hb, lb});
      end
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({ha, la, hb, lb} !== e) begin
          fails++;
          $display("FAIL %s: gates=%b expected=%b at %0t", t, {ha, la, hb, lb}, e, $time);
        end
      end
    end
  end

  task automatic cyc(input logic [3:0] v, input string tag, input int n);
    repeat (n) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
      @(negedge clk);
    end
  endtask

  task automatic to_idle();
    level = 3'b000;
    trip = 1'b0;
    cyc(4'b0000, "R1", 2);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({ha, la, hb, lb} !== 4'b0000) begin
      fails++;
      $display("FAIL R1: reset gates=%b expected=0000", {ha, la, hb, lb});
    end
    rst_n = 1'b1;
    cyc(4'b0000, "R1", 2);

    // slow decay, trip stuck high: blanking bounds each drive period
    dir = 1'b1; dsel = 2'b00; level = 3'd7; trip = 1'b1;
    cyc(4'b1001, "R3", 4);
    cyc(4'b0101, "R5", 10);
    cyc(4'b1001, "R4", 4);
    cyc(4'b0101, "R5", 3);
    trip = 1'b0;
    cyc(4'b0101, "R4", 7);
    cyc(4'b1001, "R4", 6);
    to_idle();

    // fast decay, both directions (direction changed while idle: no dead time)
    dsel = 2'b01; level = 3'd5; trip = 1'b1;
    cyc(4'b1001, "R3", 4);
    cyc(4'b0110, "R6", 10);
    cyc(4'b1001, "R2", 1);
    to_idle();
    dir = 1'b0; dsel = 2'b01; level = 3'd2; trip = 1'b1;
    cyc(4'b0110, "R8", 1);
    cyc(4'b0110, "R2", 3);
    cyc(4'b1001, "R6", 10);
    to_idle();

    // mixed decay, partial fast portion
    dir = 1'b1; dsel = 2'b10; flen = 8'd3; level = 3'd7; trip = 1'b1;
    cyc(4'b1001, "R3", 4);
    cyc(4'b0110, "R7", 3);
    cyc(4'b0101, "R7", 7);
    cyc(4'b1001, "R4", 1);
    to_idle();

    // mixed decay, fast portion clamped to off time
    dsel = 2'b11; flen = 8'd200; level = 3'd1; trip = 1'b1;
    cyc(4'b1001, "R3", 4);
    cyc(4'b0110, "R7", 10);
    cyc(4'b1001, "R7", 1);
    to_idle();

    // mixed decay, zero fast portion
    dsel = 2'b10; flen = 8'd0; level = 3'd4; trip = 1'b1;
    cyc(4'b1001, "R3", 4);
    cyc(4'b0101, "R7", 10);
    to_idle();

    // direction change during drive, with trip raised at the same time
    dir = 1'b1; dsel = 2'b00; level = 3'd7; trip = 1'b0;
    cyc(4'b1001, "R2", 5);
    dir = 1'b0; trip = 1'b1;
    cyc(4'b0000, "R8", 2);
    cyc(4'b0110, "R8", 3);
    cyc(4'b0110, "R3", 1);
    cyc(4'b0101, "R5", 2);
    to_idle();

    // zero level during drive
    dir = 1'b1; level = 3'd6; trip = 1'b0;
    cyc(4'b1001, "R2", 4);
    level = 3'b000;
    cyc(4'b0000, "R1", 2);

    // fault with hold-off
    level = 3'd7;
    cyc(4'b1001, "R2", 4);
    fault = 1'b1;
    cyc(4'b0000, "R9", 3);
    fault = 1'b0;
    cyc(4'b0000, "R9", 4);
    cyc(4'b1001, "R9", 2);

    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule